// File: doc/BRIEF.md
# Sprite and Sample DMA Arbiter

This block sits next to a 6502-style processor and takes the bus from it for two kinds of transfer. The first is a 256-byte copy into sprite memory, started when the CPU writes a page number to the sprite DMA register. The second is a single-byte fetch for an audio sample channel. That fetch is requested either when the channel's sample buffer runs empty or, after a short delay, when software sets the channel-enable bit in the audio status register.

The block stalls the CPU through its ready line. It takes the halt only on a CPU read cycle and then drives the address bus itself. The sprite copy alternates a read from the source page with a write of the same byte to the sprite data port. Reads happen only on "get" cycles of a free-running two-phase cadence, so the copy may need one alignment cycle before it starts. A sample fetch has priority over the sprite copy. When a fetch lands in the middle of a copy, it borrows a read slot and the copy then resumes with its address and count intact.

Every bus cycle is one `clk` period. Outside its transfers the block passes the CPU's address, direction and write data straight through to the bus.

Top module: `sprite_sample_dma`

## Requirements
- R1: In the cycle where `spr_reg_wr` is high, `cpu_rdy` is already low. It stays low until the copy completes.
- R2: The source page is the `cpu_wdata` value of the last `spr_reg_wr` cycle before the halt. With two back-to-back register writes, the copy uses the second value.
- R3: The copy makes 256 reads from addresses {page, n}, for n = 0 to 255 in ascending order. Each read is followed in the next cycle by a write of the byte read to address `SPR_PORT` (default 16'h2004), with `bus_rd` = 0.
- R4: The block takes the halt only in a cycle where `cpu_rd` = 1. While the CPU keeps writing, `dma_own` stays 0 even though a transfer is pending.
- R5: Cycles are numbered from 0 starting with the first cycle after reset is released. Even cycles are get cycles. Sprite reads occur only on get cycles. If the first owned cycle of a copy is odd, one idle read of `cpu_addr` is inserted first, so the copy owns the bus for 513 cycles instead of 512.
- R6: A `dmc_req` in cycle t, with the CPU reading, holds `cpu_rdy` low for exactly 4 cycles (t+1 to t+4). The fetch happens in cycle t+4: `dmc_fetch` = 1 and a read of `dmc_addr`.
- R7: A `stat_reg_wr` in cycle w with `cpu_wdata` bit 4 set leaves `cpu_rdy` high for cycles w+1 to w+3. It then holds `cpu_rdy` low for exactly 3 cycles (w+4 to w+6), with the fetch in w+6. The same write with bit 4 clear starts no fetch.
- R8: The cycle after the halt of a sample fetch is an owned dummy read that repeats `cpu_addr`.
- R9: A sample fetch requested during a copy takes the next sprite read slot, followed by one idle cycle. The copy resumes with unchanged addresses and data, and the owned span grows by exactly 2 cycles.
- R10: When a sprite copy and a sample fetch are both pending at the halt, the fetch completes before the first sprite read.
- R11: `cpu_rdy` returns high in the cycle right after the final port write. `dma_own` is never high while `cpu_rdy` is high.
- R12: After reset, `cpu_rdy` = 1, `dma_own` = 0 and `dmc_fetch` = 0, and the bus carries the CPU's address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one bus cycle per period |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | Address presented by the CPU |
| cpu_rd | input | 1 | 1 = CPU read cycle, 0 = CPU write cycle |
| cpu_wdata | input | 8 | CPU write data |
| spr_reg_wr | input | 1 | Decoded write to the sprite DMA register this cycle |
| stat_reg_wr | input | 1 | Decoded write to the audio status register this cycle |
| dmc_req | input | 1 | Sample buffer empty: request one fetch |
| dmc_addr | input | 16 | Address of the next sample byte |
| bus_rdata | input | 8 | Data returned by the bus for a read |
| cpu_rdy | output | 1 | Ready to the CPU; low stalls its reads |
| dma_own | output | 1 | Block is driving the bus this cycle |
| bus_addr | output | 16 | Bus address |
| bus_rd | output | 1 | Bus direction, 1 = read |
| bus_wdata | output | 8 | Bus write data |
| dmc_fetch | output | 1 | This cycle reads the sample byte from `bus_rdata` |

## Verification
The hardest situation to reach is a sample fetch that lands in the middle of a sprite copy. The request has to arrive while the copy is between slots, and the copy's start parity decides whether the copy itself adds an alignment cycle. The stimulus fixes the trigger cycle's parity before the register write. It then pulses the sample request a fixed distance into the copy. The owned span and the complete read and write sequences are then compared against values computed from the trigger cycle. Double register writes, requests raised while the CPU is still writing, and simultaneous sprite and sample triggers are each driven from separate directed tasks.

// File: rtl/sprite_sample_dma.sv
module sprite_sample_dma #(
  parameter logic [15:0] SPR_PORT  = 16'h2004,
  parameter int          EN_BIT    = 4,
  parameter int          ENA_DELAY = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] cpu_addr,
  input  logic        cpu_rd,
  input  logic [7:0]  cpu_wdata,
  input  logic        spr_reg_wr,
  input  logic        stat_reg_wr,
  input  logic        dmc_req,
  input  logic [15:0] dmc_addr,
  input  logic [7:0]  bus_rdata,
  output logic        cpu_rdy,
  output logic        dma_own,
  output logic [15:0] bus_addr,
  output logic        bus_rd,
  output logic [7:0]  bus_wdata,
  output logic        dmc_fetch
);

  localparam int DW = $clog2(ENA_DELAY + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_SPR_ALIGN, S_SPR_RD, S_SPR_WR, S_DMC_DUMMY, S_DMC_ALIGN, S_DMC_FETCH
  } state_t;

  state_t         state;
  logic           spr_pend, dmc_pend, dmc_short, put_phase;
  logic [7:0]     page, idx, hold;
  logic [DW-1:0]  en_cnt;

  wire halt     = (state == S_IDLE) && (spr_pend || dmc_pend) && cpu_rd;
  wire dmc_slot = (state == S_SPR_RD) && dmc_pend;
  wire spr_rd   = (state == S_SPR_RD) && !dmc_pend;
  wire last_wr  = (state == S_SPR_WR) && (idx == 8'hFF);
  wire en_fire  = (en_cnt == DW'(1));
  wire en_start = stat_reg_wr && cpu_wdata[EN_BIT];

  assign dmc_fetch = (state == S_DMC_FETCH) || dmc_slot;
  assign dma_own   = (state != S_IDLE);
  assign cpu_rdy   = !(spr_reg_wr || spr_pend || dmc_pend);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
    end else begin
      case (state)
        S_IDLE:      if (halt) state <= dmc_pend ? S_DMC_DUMMY
                                       : (put_phase ? S_SPR_RD : S_SPR_ALIGN);
        S_SPR_ALIGN: state <= S_SPR_RD;
        S_SPR_RD:    state <= dmc_pend ? S_SPR_ALIGN : S_SPR_WR;
        S_SPR_WR:    state <= (idx == 8'hFF) ? S_IDLE : S_SPR_RD;
        S_DMC_DUMMY: state <= dmc_short ? S_DMC_FETCH : S_DMC_ALIGN;
        S_DMC_ALIGN: state <= S_DMC_FETCH;
        S_DMC_FETCH: state <= S_IDLE;
        default:     state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      put_phase <= 1'b0;
      spr_pend  <= 1'b0;
      dmc_pend  <= 1'b0;
      dmc_short <= 1'b0;
      page      <= '0;
      idx       <= '0;
      hold      <= '0;
      en_cnt    <= '0;
    end else begin
      put_phase <= !put_phase;

      if (last_wr)         spr_pend <= 1'b0;
      else if (spr_reg_wr) spr_pend <= 1'b1;
      if (spr_reg_wr)      page <= cpu_wdata;

      if (halt && !dmc_pend)     idx <= '0;
      else if (state == S_SPR_WR) idx <= idx + 8'd1;
      if (spr_rd)                hold <= bus_rdata;

      if (en_start)           en_cnt <= DW'(ENA_DELAY);
      else if (en_cnt != '0)  en_cnt <= en_cnt - DW'(1);

      if (en_fire || dmc_req) dmc_pend <= 1'b1;
      else if (dmc_fetch)     dmc_pend <= 1'b0;

      if (en_fire)                    dmc_short <= 1'b1;
      else if (dmc_req && !dmc_pend)  dmc_short <= 1'b0;
    end
  end

  always_comb begin
    bus_addr  = cpu_addr;
    bus_rd    = cpu_rd;
    bus_wdata = cpu_wdata;
    case (state)
      S_SPR_RD: begin
        bus_rd   = 1'b1;
        bus_addr = dmc_pend ? dmc_addr : {page, idx};
      end
      S_SPR_WR: begin
        bus_rd    = 1'b0;
        bus_addr  = SPR_PORT;
        bus_wdata = hold;
      end
      S_SPR_ALIGN, S_DMC_DUMMY, S_DMC_ALIGN: bus_rd = 1'b1;
      S_DMC_FETCH: begin
        bus_rd   = 1'b1;
        bus_addr = dmc_addr;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/sprite_sample_dma_chk.sv
module sprite_sample_dma_chk #(
  parameter logic [15:0] PORT = 16'h2004
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cpu_rd,
  input logic        spr_reg_wr,
  input logic        cpu_rdy,
  input logic        dma_own,
  input logic        bus_rd,
  input logic [15:0] bus_addr,
  input logic        dmc_fetch,
  input logic [15:0] dmc_addr
);

  p_rdy_held_r1: assert property (@(posedge clk) disable iff (!rst_n)
    spr_reg_wr |=> !cpu_rdy);

  p_halt_on_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_own) |-> $past(cpu_rd));

  p_port_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_own && !bus_rd) |-> (bus_addr == PORT && $past(dma_own && bus_rd)));

  p_fetch_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dmc_fetch |-> (dma_own && bus_rd && bus_addr == dmc_addr));

  p_own_stalls_r11: assert property (@(posedge clk) disable iff (!rst_n)
    dma_own |-> !cpu_rdy);

endmodule

bind sprite_sample_dma sprite_sample_dma_chk #(.PORT(SPR_PORT)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_rd(cpu_rd), .spr_reg_wr(spr_reg_wr),
  .cpu_rdy(cpu_rdy), .dma_own(dma_own), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .dmc_fetch(dmc_fetch), .dmc_addr(dmc_addr)
);

// File: tb/sprite_sample_dma_tb.sv
`timescale 1ns/100ps
module sprite_sample_dma_tb;
  localparam logic [15:0] PORT  = 16'h2004;
  localparam logic [15:0] CPU_A = 16'hC0DE;
  localparam logic [15:0] DMC_A = 16'hE123;

  logic clk = 1'b0;
  always #2.5 clk = !clk;

  logic        rst_n, cpu_rd, spr_reg_wr, stat_reg_wr, dmc_req;
  logic [15:0] cpu_addr, dmc_addr;
  logic [7:0]  cpu_wdata, bus_rdata;
  logic        cpu_rdy, dma_own, bus_rd, dmc_fetch;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata;

  function automatic logic [7:0] memv(logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction
  assign bus_rdata = memv(bus_addr);

  sprite_sample_dma u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
    .cpu_wdata(cpu_wdata), .spr_reg_wr(spr_reg_wr), .stat_reg_wr(stat_reg_wr),
    .dmc_req(dmc_req), .dmc_addr(dmc_addr), .bus_rdata(bus_rdata),
    .cpu_rdy(cpu_rdy), .dma_own(dma_own), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .dmc_fetch(dmc_fetch)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  int low_cnt, first_low, rdy_back, own_cnt, first_own, fetch_cnt, fetch_cyc;
  int fetch_bad, idle_n, first_idle, rd_n, first_rd, wr_n, wr_bad, last_wr;
  logic [15:0] rd_log [0:299];
  logic [7:0]  wr_log [0:299];

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clr();
    low_cnt = 0; first_low = -1; rdy_back = -1; own_cnt = 0; first_own = -1;
    fetch_cnt = 0; fetch_cyc = -1; fetch_bad = 0; idle_n = 0; first_idle = -1;
    rd_n = 0; first_rd = -1; wr_n = 0; wr_bad = 0; last_wr = -1;
  endtask

  task automatic sample();
    if (!cpu_rdy) begin
      low_cnt++;
      if (first_low < 0) first_low = cyc;
    end else if (first_low >= 0 && rdy_back < 0) rdy_back = cyc;
    if (dma_own) begin
      own_cnt++;
      if (first_own < 0) first_own = cyc;
      if (dmc_fetch) begin
        fetch_cnt++; fetch_cyc = cyc;
        if (!(bus_rd && bus_addr == DMC_A)) fetch_bad++;
      end else if (bus_rd && bus_addr == CPU_A) begin
        idle_n++;
        if (first_idle < 0) first_idle = cyc;
      end else if (bus_rd) begin
        if (rd_n < 300) rd_log[rd_n] = bus_addr;
        if (first_rd < 0) first_rd = cyc;
        rd_n++;
      end else begin
        if (wr_n < 300) wr_log[wr_n] = bus_wdata;
        if (bus_addr != PORT) wr_bad++;
        wr_n++; last_wr = cyc;
      end
    end
  endtask

  task automatic step();
    @(negedge clk);
    sample();
    @(posedge clk);
    cyc++;
    #1;
  endtask

  task automatic quiet();
    cpu_rd = 1'b1; spr_reg_wr = 1'b0; stat_reg_wr = 1'b0; dmc_req = 1'b0;
    cpu_wdata = 8'h00;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 1200 && rdy_back < 0; i++) step();
    repeat (2) step();
  endtask

  task automatic align_to(int par);
    while ((cyc & 1) != par) step();
  endtask

  task automatic check_copy(logic [7:0] pg, string tag);
    int bad = 0;
    for (int i = 0; i < 256; i++) begin
      if (rd_log[i] != {pg, 8'(i)}) bad++;
      if (wr_log[i] != memv({pg, 8'(i)})) bad++;
    end
    chk({tag, " R3 read count"}, rd_n, 256);
    chk({tag, " R3 write count"}, wr_n, 256);
    chk({tag, " R2/R3 address and data mismatches"}, bad, 0);
    chk({tag, " R3 write to port"}, wr_bad, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R12 cpu_rdy after reset", cpu_rdy, 1);
    chk("R12 dma_own after reset", dma_own, 0);
    chk("R12 dmc_fetch after reset", dmc_fetch, 0);
    chk("R12 bus passes cpu_addr", bus_addr, CPU_A);
    @(posedge clk); cyc++; #1;
  endtask

  task automatic t_sprite(logic [7:0] pg, int par);
    int w, s;
    quiet(); align_to(par); clr();
    w = cyc; s = w + 2;
    spr_reg_wr = 1'b1; cpu_rd = 1'b0; cpu_wdata = pg;
    step();
    quiet();
    wait_done();
    chk("R1 ready low in trigger cycle", first_low, w);
    chk("R4/R5 first owned cycle", first_own, s);
    chk("R5 owned span with alignment", own_cnt, 512 + (s & 1));
    chk("R5 alignment idle reads", idle_n, s & 1);
    chk("R5 first read on get cycle", first_rd & 1, 0);
    chk("R11 ready back after last write", rdy_back, last_wr + 1);
    check_copy(pg, "sprite");
  endtask

  task automatic t_double_write();
    int w;
    quiet(); clr();
    w = cyc;
    spr_reg_wr = 1'b1; cpu_rd = 1'b0; cpu_wdata = 8'h11;
    step();
    cpu_wdata = 8'h22;
    step();
    quiet();
    wait_done();
    chk("R1 ready low from first of two writes", first_low, w);
    chk("R2 halt after second write", first_own, w + 3);
    check_copy(8'h22, "R2 double write");
  endtask

  task automatic t_dmc_empty();
    int t;
    quiet(); clr();
    t = cyc;
    dmc_req = 1'b1;
    step();
    quiet();
    repeat (10) step();
    chk("R6 ready low start", first_low, t + 1);
    chk("R6 stall length", low_cnt, 4);
    chk("R6 fetch cycle", fetch_cyc, t + 4);
    chk("R6 fetch address", fetch_bad, 0);
    chk("R8 dummy read cycle", first_idle, t + 2);
    chk("R6 dummy plus align reads", idle_n, 2);
  endtask

  task automatic t_dmc_enable(logic [7:0] val);
    int w;
    quiet(); clr();
    w = cyc;
    stat_reg_wr = 1'b1; cpu_rd = 1'b0; cpu_wdata = val;
    step();
    quiet();
    repeat (12) step();
    if (val[4]) begin
      chk("R7 ready low start", first_low, w + 4);
      chk("R7 stall length", low_cnt, 3);
      chk("R7 fetch cycle", fetch_cyc, w + 6);
      chk("R8 dummy read after halt", first_idle, w + 5);
      chk("R7 single dummy read", idle_n, 1);
    end else begin
      chk("R7 bit clear starts no fetch", fetch_cnt, 0);
      chk("R7 bit clear keeps ready", low_cnt, 0);
    end
  endtask

  task automatic t_write_wait();
    int t;
    quiet(); clr();
    t = cyc;
    dmc_req = 1'b1;
    step();
    quiet(); cpu_rd = 1'b0;
    repeat (3) step();
    cpu_rd = 1'b1;
    repeat (10) step();
    chk("R4 no ownership while CPU writes", first_own, t + 5);
    chk("R4 fetch after delayed halt", fetch_cyc, t + 7);
    chk("R4 owned cycles", own_cnt, 3);
  endtask

  task automatic t_interleave(int par);
    int w, s;
    quiet(); align_to(par); clr();
    w = cyc; s = w + 2;
    spr_reg_wr = 1'b1; cpu_rd = 1'b0; cpu_wdata = 8'h55;
    step();
    quiet();
    repeat (41) step();
    dmc_req = 1'b1;
    step();
    dmc_req = 1'b0;
    wait_done();
    chk("R9 one fetch inside copy", fetch_cnt, 1);
    chk("R9 fetch address", fetch_bad, 0);
    chk("R9 span grows by two", own_cnt, 512 + (s & 1) + 2);
    check_copy(8'h55, "R9 resumed copy");
  endtask

  task automatic t_priority();
    int w;
    quiet(); clr();
    w = cyc;
    spr_reg_wr = 1'b1; dmc_req = 1'b1; cpu_rd = 1'b0; cpu_wdata = 8'h33;
    step();
    quiet();
    wait_done();
    chk("R10 fetch first", fetch_cyc, w + 4);
    chk("R10 sprite reads after fetch", (first_rd > fetch_cyc) ? 1 : 0, 1);
    chk("R10 total owned", own_cnt, 3 + 512 + ((w + 6) & 1));
    check_copy(8'h33, "R10 copy after fetch");
  endtask

  initial begin
    rst_n = 1'b0; cpu_addr = CPU_A; dmc_addr = DMC_A;
    quiet();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    cyc = 0;
    t_reset();
    t_sprite(8'h03, 0);
    t_sprite(8'h44, 1);
    t_double_write();
    t_dmc_empty();
    t_dmc_enable(8'h10);
    t_dmc_enable(8'h0F);
    t_write_wait();
    t_interleave(0);
    t_interleave(1);
    t_priority();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    $display("FAIL watchdog: all requirements, actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
    $finish;
  end
endmodule